// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block for a USB Core

This block gathers the interrupt events of a USB controller into three sticky status registers: a general register of eight bits, and two endpoint registers of sixteen bits each. One endpoint register serves transmit and one serves receive, with one bit per endpoint. Each status register has an enable register of the same width beside it. The block also holds two small configuration registers: the endpoint selector and the device's function address. The event sources and the bus protocol are outside this block. The block sees single-cycle event pulses and a simple strobed register port.

A one-cycle pulse on an event input sets the matching status bit. The bit stays set until software reads that status register. A read returns the status as it stood before the read and clears every bit it returned. An event that arrives in the same cycle as that read is not lost. It is absent from the returned value and is set in the register afterwards. A single interrupt line is high whenever any status bit is set and the same bit is enabled, in any of the three registers.

Register select codes on `reg_sel`: 0 function address, 1 general status, 2 general enable, 3 endpoint selector, 4 transmit status, 5 receive status, 6 transmit enable, 7 receive enable. Read data appears on `rd_data` in the cycle after `rd_en` is sampled and holds until the next read.

Top module: `usb_intr_regs`

## Requirements
- R1: A one-cycle pulse on a bit of `gen_evt` sets that bit of the 8-bit general status. The bit stays set, with no further pulses, until a read of code 1.
- R2: A read of code 1 places the general status, as it was before the read, on `rd_data[7:0]` with the upper bits zero, one cycle after `rd_en`. The same read clears every returned bit.
- R3: `tx_evt` and `rx_evt` set bits of the 16-bit transmit (code 4) and receive (code 5) status. Each of those registers returns its value and clears on read exactly as in R2.
- R4: An event bit pulsed in the same cycle as a clearing read of its register is left out of the returned value. That bit is set after the read.
- R5: Writes to codes 1, 4 and 5 change no status bit.
- R6: The general enable register (code 2, 8 bits, taken from `wr_data[7:0]`) is written whole and reads back the written value. So are the transmit enable (code 6, 16 bits) and the receive enable (code 7, 16 bits). Reads of enable or configuration registers clear nothing.
- R7: A write to the endpoint selector (code 3) keeps only `wr_data[3:0]`. It reads back with the upper bits zero and is driven on `ep_index`.
- R8: A write to the function address (code 0) keeps only `wr_data[6:0]`. It reads back with the upper bits zero and is driven on `func_addr`.
- R9: `irq` is high exactly when some bit is set in both a status register and its enable register. It follows the registers in the same cycle they change.
- R10: After reset, all status, enable and configuration registers, `rd_data` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select code |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| gen_evt | input | 8 | General event pulses |
| tx_evt | input | 16 | Transmit endpoint event pulses |
| rx_evt | input | 16 | Receive endpoint event pulses |
| irq | output | 1 | Combined interrupt request |
| ep_index | output | 4 | Endpoint selector value |
| func_addr | output | 7 | Function address value |

## Verification
Any status bit that is set wrongly, lost or left uncleared shows up on `irq` in the next cycle, if that bit is enabled. Even when it is not enabled, it shows up on `rd_data` at the next read of its register. The bench keeps a behavioural model of all eight registers. It compares `rd_data` and `irq` after every clock, so a divergence is reported in the cycle it first becomes visible. The stimulus covers a read colliding with an event on the same bit and writes to status codes. It also covers over-wide writes to the narrow registers, and random traffic with sparse events.

// File: rtl/usb_intr_pkg.sv
package usb_intr_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_FADDR    = 3'd0,
    SEL_GEN_STAT = 3'd1,
    SEL_GEN_EN   = 3'd2,
    SEL_EP_IDX   = 3'd3,
    SEL_TX_STAT  = 3'd4,
    SEL_RX_STAT  = 3'd5,
    SEL_TX_EN    = 3'd6,
    SEL_RX_EN    = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/rc_status_reg.sv
// Sticky status register: set by event pulses, cleared whole by a read strobe.
module rc_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic         upd;

  // The read returns stat_q, so dropping stat_q clears exactly the returned bits;
  // events of this cycle are ORed in afterwards and survive.
  always_comb begin
    stat_d = (rd_clr_i ? '0 : stat_q) | evt_i;
    upd    = rd_clr_i | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_read_keeps_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (stat_q == $past(evt_i)));

endmodule

// File: rtl/cfg_reg.sv
// Plain write-whole register keeping the low W bits of the bus.
module cfg_reg #(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [W-1:0]      q_o
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb q_d = wdata_i[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (we_i) q_q <= q_d;
  end

  assign q_o = q_q;

  // R6, R7, R8: a write loads the truncated bus value.
  p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(wdata_i[W-1:0])));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));

endmodule

// File: rtl/irq_combine.sv
// Reduces status AND enable of the three sources to one request line.
module irq_combine #(
  parameter int unsigned GEN_W = 8,
  parameter int unsigned EP_N  = 16
) (
  input  logic [GEN_W-1:0] gen_stat_i,
  input  logic [GEN_W-1:0] gen_en_i,
  input  logic [EP_N-1:0]  tx_stat_i,
  input  logic [EP_N-1:0]  tx_en_i,
  input  logic [EP_N-1:0]  rx_stat_i,
  input  logic [EP_N-1:0]  rx_en_i,
  output logic             irq_o
);

  logic [EP_N-1:0] ep_pend;
  logic            gen_pend;

  for (genvar e = 0; e < EP_N; e++) begin : g_ep
    assign ep_pend[e] = (tx_stat_i[e] & tx_en_i[e]) | (rx_stat_i[e] & rx_en_i[e]);
  end

  assign gen_pend = |(gen_stat_i & gen_en_i);
  assign irq_o    = gen_pend | (|ep_pend);

endmodule

// File: rtl/usb_intr_regs.sv
module usb_intr_regs
  import usb_intr_pkg::*;
#(
  parameter int unsigned GEN_W   = 8,
  parameter int unsigned EP_N    = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned FADDR_W = 7,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [GEN_W-1:0]   gen_evt,
  input  logic [EP_N-1:0]    tx_evt,
  input  logic [EP_N-1:0]    rx_evt,
  output logic               irq,
  output logic [IDX_W-1:0]   ep_index,
  output logic [FADDR_W-1:0] func_addr
);

  localparam int unsigned NUM_SEL = 1 << SEL_W;

  reg_sel_e          sel;
  logic [NUM_SEL-1:0] wr_hit;
  logic [NUM_SEL-1:0] rd_hit;

  logic [GEN_W-1:0]  gen_stat, gen_en;
  logic [EP_N-1:0]   tx_stat, rx_stat, tx_en, rx_en;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  assign sel = reg_sel_e'(reg_sel);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_dec
    assign wr_hit[i] = wr_en & (reg_sel == SEL_W'(i));
    assign rd_hit[i] = rd_en & (reg_sel == SEL_W'(i));
  end

  // Status registers: writes never reach them (R5).
  rc_status_reg #(.W(GEN_W)) u_gen_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(gen_evt),
    .rd_clr_i(rd_hit[SEL_GEN_STAT]), .stat_o(gen_stat));

  rc_status_reg #(.W(EP_N)) u_tx_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(tx_evt),
    .rd_clr_i(rd_hit[SEL_TX_STAT]), .stat_o(tx_stat));

  rc_status_reg #(.W(EP_N)) u_rx_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(rx_evt),
    .rd_clr_i(rd_hit[SEL_RX_STAT]), .stat_o(rx_stat));

  cfg_reg #(.W(GEN_W), .DATA_W(DATA_W)) u_gen_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[SEL_GEN_EN]), .wdata_i(wr_data), .q_o(gen_en));

  cfg_reg #(.W(EP_N), .DATA_W(DATA_W)) u_tx_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[SEL_TX_EN]), .wdata_i(wr_data), .q_o(tx_en));

  cfg_reg #(.W(EP_N), .DATA_W(DATA_W)) u_rx_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[SEL_RX_EN]), .wdata_i(wr_data), .q_o(rx_en));

  cfg_reg #(.W(IDX_W), .DATA_W(DATA_W)) u_ep_idx (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[SEL_EP_IDX]), .wdata_i(wr_data), .q_o(ep_index));

  cfg_reg #(.W(FADDR_W), .DATA_W(DATA_W)) u_faddr (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit[SEL_FADDR]), .wdata_i(wr_data), .q_o(func_addr));

  irq_combine #(.GEN_W(GEN_W), .EP_N(EP_N)) u_irq (
    .gen_stat_i(gen_stat), .gen_en_i(gen_en),
    .tx_stat_i(tx_stat), .tx_en_i(tx_en),
    .rx_stat_i(rx_stat), .rx_en_i(rx_en),
    .irq_o(irq));

  // Read mux, zero-extended to the bus width.
  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_FADDR:    rd_mux[FADDR_W-1:0] = func_addr;
      SEL_GEN_STAT: rd_mux[GEN_W-1:0]   = gen_stat;
      SEL_GEN_EN:   rd_mux[GEN_W-1:0]   = gen_en;
      SEL_EP_IDX:   rd_mux[IDX_W-1:0]   = ep_index;
      SEL_TX_STAT:  rd_mux[EP_N-1:0]    = tx_stat;
      SEL_RX_STAT:  rd_mux[EP_N-1:0]    = rx_stat;
      SEL_TX_EN:    rd_mux[EP_N-1:0]    = tx_en;
      SEL_RX_EN:    rd_mux[EP_N-1:0]    = rx_en;
      default:      rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  p_read_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == SEL_GEN_STAT) |=> (rd_data[GEN_W-1:0] == $past(gen_stat)));

  p_read_returns_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == SEL_TX_STAT) |=> (rd_data[EP_N-1:0] == $past(tx_stat)));

  p_status_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && gen_evt == '0 && reg_sel == SEL_GEN_STAT) |=> $stable(gen_stat));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en == '0 && tx_en == '0 && rx_en == '0) |-> !irq);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/usb_intr_regs_tb.sv
module usb_intr_regs_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  reg_sel;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [7:0]  gen_evt;
  logic [15:0] tx_evt, rx_evt;
  logic        irq;
  logic [3:0]  ep_index;
  logic [6:0]  func_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model state
  logic [7:0]  m_gen, m_gen_en;
  logic [15:0] m_tx, m_rx, m_tx_en, m_rx_en, m_rd;
  logic [3:0]  m_idx;
  logic [6:0]  m_fa;

  usb_intr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .gen_evt(gen_evt), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .irq(irq), .ep_index(ep_index), .func_addr(func_addr));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_value(input logic [2:0] a);
    case (a)
      3'd0: return {9'd0, m_fa};
      3'd1: return {8'd0, m_gen};
      3'd2: return {8'd0, m_gen_en};
      3'd3: return {12'd0, m_idx};
      3'd4: return m_tx;
      3'd5: return m_rx;
      3'd6: return m_tx_en;
      default: return m_rx_en;
    endcase
  endfunction

  // One clock: drive, update model at the edge, compare at the following negedge.
  task automatic step(input bit we, input bit re, input logic [2:0] a, input logic [15:0] wd,
                      input logic [7:0] ge, input logic [15:0] te, input logic [15:0] rxe,
                      input string tag);
    wr_en = we; rd_en = re; reg_sel = a; wr_data = wd;
    gen_evt = ge; tx_evt = te; rx_evt = rxe;
    @(posedge clk);
    if (re) begin
      m_rd = m_value(a);
      if (a == 3'd1) m_gen = '0;
      if (a == 3'd4) m_tx  = '0;
      if (a == 3'd5) m_rx  = '0;
    end
    m_gen |= ge; m_tx |= te; m_rx |= rxe;
    if (we) begin
      case (a)
        3'd0: m_fa     = wd[6:0];
        3'd2: m_gen_en = wd[7:0];
        3'd3: m_idx    = wd[3:0];
        3'd6: m_tx_en  = wd;
        3'd7: m_rx_en  = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    chk({tag, " rd_data"}, rd_data, m_rd);
    chk({tag, " irq R9"}, {15'd0, irq},
        {15'd0, (|(m_gen & m_gen_en)) | (|(m_tx & m_tx_en)) | (|(m_rx & m_rx_en))});
    chk({tag, " ep_index R7"}, {12'd0, ep_index}, {12'd0, m_idx});
    chk({tag, " func_addr R8"}, {9'd0, func_addr}, {9'd0, m_fa});
    wr_en = 0; rd_en = 0; gen_evt = '0; tx_evt = '0; rx_evt = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(0, 1, a, 16'h0, 8'h0, 16'h0, 16'h0, tag);
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(1, 0, a, d, 8'h0, 16'h0, 16'h0, tag);
  endtask
  task automatic ev(input logic [7:0] g, input logic [15:0] t, input logic [15:0] r, input string tag);
    step(0, 0, 3'd0, 16'h0, g, t, r, tag);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; reg_sel = '0; wr_data = '0;
    gen_evt = '0; tx_evt = '0; rx_evt = '0;
    m_gen = '0; m_gen_en = '0; m_tx = '0; m_rx = '0; m_tx_en = '0; m_rx_en = '0;
    m_rd = '0; m_idx = '0; m_fa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 rd_data", rd_data, 16'h0);
    chk("R10 irq", {15'd0, irq}, 16'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), "R10 reset read");
      chk("R10 register zero", rd_data, 16'h0);
    end

    // R1/R2: general events stick and read-clear
    ev(8'h05, 16'h0, 16'h0, "R1 set");
    ev(8'h00, 16'h0, 16'h0, "R1 hold");
    rd(3'd2, "R6 no clear on enable read");
    rd(3'd1, "R2 read");
    chk("R2 returned", rd_data, 16'h0005);
    rd(3'd1, "R2 reread");
    chk("R2 cleared", rd_data, 16'h0000);

    // R5: status writes ignored
    ev(8'h10, 16'h0002, 16'h0004, "R5 pre");
    wr(3'd1, 16'hFFFF, "R5 wr gen");
    wr(3'd1, 16'h0000, "R5 wr gen zero");
    wr(3'd4, 16'hFFFF, "R5 wr tx");
    wr(3'd5, 16'h0000, "R5 wr rx");
    rd(3'd1, "R5 read gen");
    chk("R5 gen unchanged", rd_data, 16'h0010);
    rd(3'd4, "R5 read tx");
    chk("R5 tx unchanged", rd_data, 16'h0002);
    rd(3'd5, "R5 read rx");
    chk("R5 rx unchanged", rd_data, 16'h0004);

    // R3: endpoint registers
    ev(8'h00, 16'h8001, 16'h0100, "R3 set");
    ev(8'h00, 16'h0040, 16'h0000, "R3 set2");
    rd(3'd4, "R3 read tx");
    chk("R3 tx value", rd_data, 16'h8041);
    rd(3'd5, "R3 read rx");
    chk("R3 rx value", rd_data, 16'h0100);
    rd(3'd4, "R3 tx cleared");
    chk("R3 tx zero", rd_data, 16'h0000);

    // R4: event colliding with a clearing read
    ev(8'h02, 16'h0, 16'h0, "R4 pre");
    step(0, 1, 3'd1, 16'h0, 8'h82, 16'h0, 16'h0, "R4 collide gen");
    chk("R4 returned excludes new", rd_data, 16'h0002);
    rd(3'd1, "R4 survivor");
    chk("R4 survivor value", rd_data, 16'h0082);
    ev(8'h00, 16'h0010, 16'h0, "R4 tx pre");
    step(0, 1, 3'd4, 16'h0, 8'h00, 16'h0020, 16'h0, "R4 collide tx");
    chk("R4 tx returned", rd_data, 16'h0010);
    rd(3'd4, "R4 tx survivor");
    chk("R4 tx survivor value", rd_data, 16'h0020);

    // R6/R9: enables and interrupt
    wr(3'd2, 16'hFF04, "R6 gen en");
    rd(3'd2, "R6 gen en read");
    chk("R6 gen en value", rd_data, 16'h0004);
    ev(8'h08, 16'h0, 16'h0, "R9 masked event");
    chk("R9 masked no irq", {15'd0, irq}, 16'h0);
    ev(8'h04, 16'h0, 16'h0, "R9 enabled event");
    chk("R9 irq high", {15'd0, irq}, 16'h0001);
    rd(3'd1, "R9 clear by read");
    chk("R9 irq low", {15'd0, irq}, 16'h0000);
    wr(3'd6, 16'hA5A5, "R6 tx en");
    wr(3'd7, 16'h5A5A, "R6 rx en");
    rd(3'd6, "R6 tx en read");
    chk("R6 tx en value", rd_data, 16'hA5A5);
    rd(3'd7, "R6 rx en read");
    chk("R6 rx en value", rd_data, 16'h5A5A);
    ev(8'h0, 16'h0, 16'h0002, "R9 rx irq");
    chk("R9 rx irq", {15'd0, irq}, 16'h0001);
    rd(3'd5, "R9 rx clear");
    ev(8'h0, 16'h0002, 16'h0, "R9 tx masked");
    chk("R9 tx masked", {15'd0, irq}, 16'h0000);
    rd(3'd4, "R9 tx clear");

    // R7/R8: narrow registers
    wr(3'd3, 16'hFFFF, "R7 idx");
    rd(3'd3, "R7 idx read");
    chk("R7 idx value", rd_data, 16'h000F);
    wr(3'd0, 16'hFFFF, "R8 fa");
    rd(3'd0, "R8 fa read");
    chk("R8 fa value", rd_data, 16'h007F);
    wr(3'd0, 16'h1234, "R8 fa2");
    chk("R8 fa port", {9'd0, func_addr}, 16'h0034);

    // Random traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  a;
      logic [15:0] d;
      bit we, re;
      a  = 3'($urandom_range(0, 7));
      d  = 16'($urandom);
      we = ($urandom_range(0, 3) == 0);
      re = !we && ($urandom_range(0, 2) == 0);
      step(we, re, a, d,
           ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h0,
           ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0,
           ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0,
           "R1 R3 R4 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule